// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block merges three independent reasons to reset a microcontroller into one reset signal that, once raised, stays raised for a guaranteed minimum time. The reasons are an undervoltage flag from an external analog comparator, an active-low push-button input, and a watchdog that expects the host software to toggle a service pin regularly. Every input is asynchronous and passes through a two-stage synchroniser before it is used.

Timing is set in physical units (microseconds and nanoseconds) and converted to clock cycles at elaboration from the clock frequency parameter. The push-button path carries a minimum-width filter that rejects short glitches while still reacting well within half a microsecond. Either the watchdog or the push-button path can be removed by parameter. The reset leaves the block in two forms, active-low and active-high, which always mirror each other.

Top module: `rst_supervisor`

## Requirements
- R1: While `uv_i` is high, reset is asserted (`rst_n_o` = 0) no later than 4 clock cycles after `uv_i` rises and remains asserted for as long as `uv_i` stays high.
- R2: Once every reset cause has gone inactive, reset stays asserted for the hold period (HOLD_US converted to cycles, within a few cycles of synchroniser latency) and is then released.
- R3: If `uv_i` goes high again while the hold period is running, the hold count restarts from zero, and release happens one full hold period after `uv_i` last falls.
- R4: A low level on `mr_n_i` lasting 1 µs or more asserts reset within 500 ns of the falling edge; after `mr_n_i` returns high, the hold period of R2 applies.
- R5: A low pulse on `mr_n_i` shorter than 100 ns has no effect on the reset outputs.
- R6: If no edge appears on `svc_i` for the watchdog period (WDOG_US converted to cycles), reset is asserted and then held for one full hold period.
- R7: A rising or a falling edge on `svc_i` restarts the watchdog period; high pulses as short as 50 ns are detected, so servicing at intervals shorter than the watchdog period keeps reset released.
- R8: The watchdog counter is held at zero while reset is asserted and begins counting at the cycle reset is released, so an unserviced watchdog expires one watchdog period after each release.
- R9: `rst_o` is at every clock edge the logical inverse of `rst_n_o`.
- R10: While `por_n_i` is low, reset is asserted at once (asynchronously); after `por_n_i` rises, with no other cause active, reset is released after the hold period.
- R11: With WDOG_EN = 0 the service input never causes a reset; with MRST_EN = 0 the push-button input never causes a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock of CLK_HZ hertz |
| por_n_i | input | 1 | Asynchronous power-on clear, active low |
| uv_i | input | 1 | Undervoltage flag from the external comparator, active high, asynchronous |
| mr_n_i | input | 1 | Push-button reset request, active low, asynchronous |
| svc_i | input | 1 | Watchdog service pin, toggled by the host, asynchronous |
| rst_n_o | output | 1 | Reset to the host, active low |
| rst_o | output | 1 | Reset to the host, active high, inverse of rst_n_o |

## Verification
A wrong hold count shows as a release that comes early or late against the hold period measured from the last cause, visible at the first release after any cause. A watchdog counter that is not cleared during reset, or that misses one of the two service edges, shows as a reset arriving sooner than one full watchdog period after release or after the last service edge, so the error becomes visible within one watchdog period. A filter that is too short or too long shows either as a reset on a sub-100 ns glitch or as a push-button response later than 500 ns, within a few dozen cycles of the press.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

   // Round up a time in microseconds to whole clock cycles.
   function automatic int unsigned us_to_cyc(input longint unsigned hz,
                                             input longint unsigned us);
      longint unsigned prod;
      prod = hz * us;
      return int'((prod + 64'd999_999) / 64'd1_000_000);
   endfunction

   // Round up a time in nanoseconds to whole clock cycles.
   function automatic int unsigned ns_to_cyc(input longint unsigned hz,
                                             input longint unsigned ns);
      longint unsigned prod;
      prod = hz * ns;
      return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
   endfunction

   // Counter width able to hold values 0 .. n.
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   // Bit positions of the synchronised input vector.
   localparam int unsigned SYN_UV  = 0;
   localparam int unsigned SYN_MR  = 1;
   localparam int unsigned SYN_SVC = 2;
   localparam int unsigned SYN_W   = 3;

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
   parameter int unsigned    W       = 1,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         por_n_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         logic [1:0] stage;
         always_ff @(posedge clk_i or negedge por_n_i) begin
            if (!por_n_i) begin
               stage <= {2{RST_VAL[b]}};
            end else begin
               stage <= {stage[0], d_i[b]};
            end
         end
         assign q_o[b] = stage[1];
      end
   endgenerate

endmodule

// File: rtl/rsup_mr_filter.sv
module rsup_mr_filter #(
   parameter int unsigned FILT_CYC = 10
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic mr_n_s_i,
   output logic act_o
);

   localparam int unsigned CW = rsup_pkg::cnt_w(FILT_CYC);
   localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

   logic [CW-1:0] low_cnt;
   logic          act_q;

   // Accept the request only after FILT_CYC consecutive low samples;
   // drop it on the first high sample.
   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         low_cnt <= '0;
         act_q   <= 1'b0;
      end else if (mr_n_s_i) begin
         low_cnt <= '0;
         act_q   <= 1'b0;
      end else if (!act_q) begin
         if (low_cnt == LAST) begin
            act_q <= 1'b1;
         end else begin
            low_cnt <= low_cnt + 1'b1;
         end
      end
   end

   assign act_o = act_q;

endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog #(
   parameter int unsigned WD_CYC = 3000,
   parameter int unsigned WD_W   = 12
) (
   input  logic            clk_i,
   input  logic            por_n_i,
   input  logic            svc_s_i,
   input  logic            rst_act_i,
   output logic            exp_o,
   output logic [WD_W-1:0] cnt_o
);

   localparam logic [WD_W-1:0] LAST = WD_W'(WD_CYC - 1);

   logic            svc_d;
   logic            svc_edge;
   logic [WD_W-1:0] cnt_q;
   logic            at_last;

   assign svc_edge = svc_s_i ^ svc_d;
   assign at_last  = (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         svc_d <= 1'b0;
      end else begin
         svc_d <= svc_s_i;
      end
   end

   // Held at zero during reset and on each service edge; stops at the
   // terminal value, where the expiry request is raised.
   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         cnt_q <= '0;
      end else if (rst_act_i || svc_edge) begin
         cnt_q <= '0;
      end else if (!at_last) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign exp_o = at_last && !rst_act_i;
   assign cnt_o = cnt_q;

endmodule

// File: rtl/rsup_hold.sv
module rsup_hold #(
   parameter int unsigned HOLD_CYC = 1000,
   parameter int unsigned HOLD_W   = 10
) (
   input  logic              clk_i,
   input  logic              por_n_i,
   input  logic              cause_i,
   output logic              rst_o,
   output logic [HOLD_W-1:0] cnt_o
);

   localparam logic [HOLD_W-1:0] LAST = HOLD_W'(HOLD_CYC - 1);

   logic              rst_q;
   logic [HOLD_W-1:0] cnt_q;

   // Any active cause forces reset and zeroes the hold count; the count
   // only advances once all causes are gone.
   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         rst_q <= 1'b1;
         cnt_q <= '0;
      end else if (cause_i) begin
         rst_q <= 1'b1;
         cnt_q <= '0;
      end else if (rst_q) begin
         if (cnt_q == LAST) begin
            rst_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign rst_o = rst_q;
   assign cnt_o = cnt_q;

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
   parameter int unsigned CLK_HZ     = 50_000_000,
   parameter int unsigned HOLD_US    = 200_000,
   parameter int unsigned WDOG_US    = 1_600_000,
   parameter int unsigned MR_FILT_NS = 200,
   parameter bit          WDOG_EN    = 1'b1,
   parameter bit          MRST_EN    = 1'b1
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic uv_i,
   input  logic mr_n_i,
   input  logic svc_i,
   output logic rst_n_o,
   output logic rst_o
);

   import rsup_pkg::*;

   localparam int unsigned HOLD_CYC = us_to_cyc(CLK_HZ, HOLD_US);
   localparam int unsigned WD_CYC   = us_to_cyc(CLK_HZ, WDOG_US);
   localparam int unsigned FILT_CYC = ns_to_cyc(CLK_HZ, MR_FILT_NS);
   localparam int unsigned HOLD_W   = cnt_w(HOLD_CYC);
   localparam int unsigned WD_W     = cnt_w(WD_CYC);
   localparam logic [SYN_W-1:0] SYN_RST = SYN_W'(3'b011);

   // Elaboration checks on the parameter set.
   generate
      if (CLK_HZ < 40_000_000) begin : g_bad_clk
         $error("CLK_HZ too low: a 50 ns service pulse must span two clock periods");
      end
      if (MR_FILT_NS < 100 || MR_FILT_NS > 400) begin : g_bad_filt
         $error("MR_FILT_NS must lie in 100..400 to reject glitches and meet the 500 ns response");
      end
      if (HOLD_CYC < 2) begin : g_bad_hold
         $error("hold period shorter than two clock cycles");
      end
      if (WD_CYC < 2) begin : g_bad_wd
         $error("watchdog period shorter than two clock cycles");
      end
   endgenerate

   logic [SYN_W-1:0]  raw_in;
   logic [SYN_W-1:0]  syn_in;
   logic              uv_s;
   logic              mr_act;
   logic              wd_exp;
   logic [WD_W-1:0]   wd_cnt;
   logic              rst_q;
   logic [HOLD_W-1:0] hold_cnt;
   logic              cause;

   assign raw_in[SYN_UV]  = uv_i;
   assign raw_in[SYN_MR]  = mr_n_i;
   assign raw_in[SYN_SVC] = svc_i;

   rsup_sync #(
      .W       (SYN_W),
      .RST_VAL (SYN_RST)
   ) u_sync (
      .clk_i   (clk_i),
      .por_n_i (por_n_i),
      .d_i     (raw_in),
      .q_o     (syn_in)
   );

   assign uv_s = syn_in[SYN_UV];

   generate
      if (MRST_EN) begin : g_mr
         rsup_mr_filter #(
            .FILT_CYC (FILT_CYC)
         ) u_mr (
            .clk_i    (clk_i),
            .por_n_i  (por_n_i),
            .mr_n_s_i (syn_in[SYN_MR]),
            .act_o    (mr_act)
         );
      end else begin : g_no_mr
         assign mr_act = 1'b0;
      end

      if (WDOG_EN) begin : g_wd
         rsup_wdog #(
            .WD_CYC (WD_CYC),
            .WD_W   (WD_W)
         ) u_wd (
            .clk_i     (clk_i),
            .por_n_i   (por_n_i),
            .svc_s_i   (syn_in[SYN_SVC]),
            .rst_act_i (rst_q),
            .exp_o     (wd_exp),
            .cnt_o     (wd_cnt)
         );
      end else begin : g_no_wd
         assign wd_exp = 1'b0;
         assign wd_cnt = '0;
      end
   endgenerate

   assign cause = uv_s | mr_act | wd_exp;

   rsup_hold #(
      .HOLD_CYC (HOLD_CYC),
      .HOLD_W   (HOLD_W)
   ) u_hold (
      .clk_i   (clk_i),
      .por_n_i (por_n_i),
      .cause_i (cause),
      .rst_o   (rst_q),
      .cnt_o   (hold_cnt)
   );

   assign rst_o   = rst_q;
   assign rst_n_o = ~rst_q;

endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
   parameter int unsigned HOLD_CYC = 1000,
   parameter int unsigned HOLD_W   = 10,
   parameter int unsigned WD_W     = 12
) (
   input logic              clk_i,
   input logic              por_n_i,
   input logic              rst_n_o,
   input logic              rst_o,
   input logic              uv_s,
   input logic              mr_act,
   input logic              wd_exp,
   input logic [WD_W-1:0]   wd_cnt,
   input logic              rst_q,
   input logic [HOLD_W-1:0] hold_cnt
);

   AST_OUT_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!por_n_i)
      rst_o != rst_n_o); // R9

   AST_UV_FORCES_RST: assert property (@(posedge clk_i) disable iff (!por_n_i)
      uv_s |=> rst_q); // R1

   AST_UV_CLEARS_HOLD: assert property (@(posedge clk_i) disable iff (!por_n_i)
      uv_s |=> (hold_cnt == '0)); // R3

   AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $fell(rst_q) |-> ($past(hold_cnt) == HOLD_W'(HOLD_CYC - 1))); // R2

   AST_MR_FORCES_RST: assert property (@(posedge clk_i) disable iff (!por_n_i)
      mr_act |=> rst_q); // R4

   AST_WD_EXPIRY_RST: assert property (@(posedge clk_i) disable iff (!por_n_i)
      wd_exp |=> rst_q); // R6

   AST_WD_HELD_IN_RST: assert property (@(posedge clk_i) disable iff (!por_n_i)
      rst_q |=> (wd_cnt == '0)); // R8

   AST_NO_EXP_IN_RST: assert property (@(posedge clk_i) disable iff (!por_n_i)
      rst_q |-> !wd_exp); // R8

endmodule

bind rst_supervisor rst_supervisor_chk #(
   .HOLD_CYC (HOLD_CYC),
   .HOLD_W   (HOLD_W),
   .WD_W     (WD_W)
) chk_i (
   .clk_i    (clk_i),
   .por_n_i  (por_n_i),
   .rst_n_o  (rst_n_o),
   .rst_o    (rst_o),
   .uv_s     (uv_s),
   .mr_act   (mr_act),
   .wd_exp   (wd_exp),
   .wd_cnt   (wd_cnt),
   .rst_q    (rst_q),
   .hold_cnt (hold_cnt)
);

// File: tb/rst_supervisor_tb_top.sv
`timescale 1ns/1ps
module rst_supervisor_tb_top;

   localparam int HOLD = 1000;   // 20 us at 50 MHz
   localparam int WD   = 3000;   // 60 us at 50 MHz

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic uv = 1'b0;
   logic mr_n = 1'b1;
   logic svc = 1'b0;
   logic svc_en = 1'b0;
   logic rst_n, rst;
   logic off_rst_n, off_rst;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   rst_supervisor #(
      .CLK_HZ(50_000_000), .HOLD_US(20), .WDOG_US(60), .MR_FILT_NS(200),
      .WDOG_EN(1'b1), .MRST_EN(1'b1)
   ) dut_i (
      .clk_i(clk), .por_n_i(por_n), .uv_i(uv), .mr_n_i(mr_n), .svc_i(svc),
      .rst_n_o(rst_n), .rst_o(rst)
   );

   rst_supervisor #(
      .CLK_HZ(50_000_000), .HOLD_US(20), .WDOG_US(60), .MR_FILT_NS(200),
      .WDOG_EN(1'b0), .MRST_EN(1'b0)
   ) dut_off_i (
      .clk_i(clk), .por_n_i(por_n), .uv_i(uv), .mr_n_i(mr_n), .svc_i(svc),
      .rst_n_o(off_rst_n), .rst_o(off_rst)
   );

   // Background service toggler.
   initial begin
      forever begin
         repeat (500) @(negedge clk);
         if (svc_en) svc = ~svc;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic chk_range(input string req, input int n, input int lo, input int hi);
      n_chk++;
      if (n < lo || n > hi) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, n, lo, hi);
      end
   endtask

   // Cycles until rst_n reaches tgt (polled at negedges).
   task automatic meas(input logic tgt, input int lim, output int n);
      n = 0;
      while (rst_n !== tgt && n < lim) begin
         @(negedge clk);
         n++;
      end
   endtask

   // Count cycles with reset asserted over a window.
   task automatic watch(input int cyc, output int hits);
      hits = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (rst_n !== 1'b1) hits++;
      end
   endtask

   task automatic t_por;
      int n;
      por_n = 1'b0;
      #1;
      chk(rst_n === 1'b0, "R10 rst_n in por", int'(rst_n), 0);
      chk(rst === 1'b1, "R9 rst in por", int'(rst), 1);
      chk(off_rst_n === 1'b0, "R10 off rst_n in por", int'(off_rst_n), 0);
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      meas(1'b1, 2000, n);
      chk_range("R10 release after por", n, HOLD - 5, HOLD + 8);
      chk(rst === 1'b0, "R9 rst after release", int'(rst), 0);
   endtask

   task automatic t_uv;
      int n;
      uv = 1'b1;
      meas(1'b0, 20, n);
      chk_range("R1 uv assert latency", n, 1, 4);
      repeat (200) @(negedge clk);
      chk(rst_n === 1'b0, "R1 held during uv", int'(rst_n), 0);
      chk(rst === 1'b1, "R9 inverse during uv", int'(rst), 1);
      uv = 1'b0;
      meas(1'b1, 2000, n);
      chk_range("R2 hold after uv", n, HOLD - 5, HOLD + 8);
   endtask

   task automatic t_uv_restart;
      int n;
      uv = 1'b1;
      repeat (10) @(negedge clk);
      uv = 1'b0;
      repeat (500) @(negedge clk);
      uv = 1'b1;
      repeat (10) @(negedge clk);
      uv = 1'b0;
      meas(1'b1, 2000, n);
      chk_range("R3 hold restart", n, HOLD - 5, HOLD + 8);
   endtask

   task automatic t_mr;
      int n;
      mr_n = 1'b0;
      meas(1'b0, 40, n);
      chk_range("R4 mr latency", n, 10, 25);
      repeat (50 - n) @(negedge clk);
      chk(off_rst_n === 1'b1, "R11 mr disabled", int'(off_rst_n), 1);
      mr_n = 1'b1;
      meas(1'b1, 2000, n);
      chk_range("R4 hold after mr", n, HOLD - 5, HOLD + 10);
   endtask

   task automatic t_mr_glitch;
      int h;
      mr_n = 1'b0;
      repeat (4) @(negedge clk);
      mr_n = 1'b1;
      watch(40, h);
      chk(h == 0, "R5 glitch ignored", h, 0);
   endtask

   task automatic t_service;
      int h;
      watch(8000, h);
      chk(h == 0, "R7 toggling service", h, 0);
      svc_en = 1'b0;
      @(negedge clk);
      svc = 1'b0;
      for (int k = 0; k < 4; k++) begin
         watch(1500, h);
         chk(h == 0, "R7 short pulses", h, 0);
         #3 svc = 1'b1;
         #50 svc = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic t_expiry;
      int n;
      meas(1'b0, 4000, n);
      chk_range("R6 expiry time", n, WD - 10, WD + 12);
      meas(1'b1, 2000, n);
      chk_range("R6 hold after expiry", n, HOLD - 5, HOLD + 5);
      meas(1'b0, 4000, n);
      chk_range("R8 count from release", n, WD - 10, WD + 10);
      chk(off_rst_n === 1'b1, "R11 watchdog disabled", int'(off_rst_n), 1);
      meas(1'b1, 2000, n);
      chk_range("R8 hold again", n, HOLD - 5, HOLD + 5);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      svc_en = 1'b1;
      t_por();
      t_uv();
      t_uv_restart();
      t_mr();
      t_mr_glitch();
      t_service();
      t_expiry();
      svc_en = 1'b1;
      t_por();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule